// File: doc/BRIEF.md
# Master-Mode Audio Clock Generator

This block produces the serial-port timing of an audio converter that owns the clocks. From the master clock (`mclk_i`) it derives three signals. The first is a bit clock. The second is a frame (left/right) clock. The third is a one-cycle enable that paces a sigma-delta modulator. It also reports the oversampling ratio that the modulator should use.

A 2-bit rate select picks one of three settings. The frame rate, the bit-clock divider and the modulator pacing all change together with that setting. In each setting the modulator runs near its optimal rate when the matching master clock frequency is used.

All three clocks come from one free-running divider counter, so they stay in phase. Any change to the decoded setting, or to the master/slave select, restarts that counter. In slave mode the generated clocks are held idle.

Top module: `audio_clkgen`

Timing terms used below: phase k counts `mclk_i` rising edges since the last restart. The restart edge itself has k = 0. Outputs change just after each edge.

## Requirements
- R1: While `rst_ni` is low, `bclk_o`, `lrclk_o` and `mod_en_o` are 0 and `osr_o` is 128.
- R2: In master mode with rate select 2'b00, `lrclk_o` is 1 exactly when (k mod 256) >= 128, and `bclk_o` is 1 exactly when (k mod 4) >= 2. `mod_en_o` is 1 exactly when k mod 2 = 1.
- R3: In master mode with rate select 2'b01, `lrclk_o` follows the same 256-cycle frame as in R2 and `bclk_o` follows the same 4-cycle period. `mod_en_o` is 1 exactly when k mod 4 = 3.
- R4: In master mode with rate select 2'b10, `lrclk_o` is 1 exactly when (k mod 128) >= 64, and `bclk_o` is 1 exactly when k mod 2 = 1. `mod_en_o` is 1 exactly when k mod 4 = 3.
- R5: One edge after the rate select is sampled, `osr_o` shows the matching ratio: 128 for 2'b00, 64 for 2'b01, 32 for 2'b10 and 128 for 2'b11. This holds in both master and slave mode.
- R6: Without a restart, `lrclk_o` changes only on the same edge on which `bclk_o` falls from 1 to 0.
- R7: `mod_en_o` is never high on two consecutive cycles.
- R8: With `master_i` = 0, `bclk_o`, `lrclk_o` and `mod_en_o` are 0 from the first edge after `master_i` is sampled at 0.
- R9: A change of `master_i`, or a change of the decoded rate, restarts the divider. The first edge that samples the new value is phase k = 0, so `lrclk_o` and `bclk_o` both start low.
- R10: Rate select 2'b11 decodes as 2'b00. Switching between 2'b00 and 2'b11 causes no restart, and the phase carries on without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master (generate clocks), 0 = slave (idle) |
| rate_sel_i | input | 2 | Rate select: 00 normal, 01 double, 10 quad, 11 = 00 |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, low half first |
| mod_en_o | output | 1 | One-cycle modulator clock enable |
| osr_o | output | 8 | Active modulator oversampling ratio |

## Verification
The bench walks every rate code in master mode over complete frames. It compares each output on every cycle against a phase computed arithmetically from the restart point. A divider that wraps at the wrong count, or that taps the wrong bit, drifts visibly within one frame.

The bench also makes mid-frame switches. A design that failed to restart would continue with a frame clock stuck high. The 2'b00 to 2'b11 switch catches a decoder that restarts on a raw code change, since the phase would snap back to zero.

A slave interval checks that the clocks go idle. A check on the frame edges looks for any frame clock transition that does not fall on a bit-clock falling edge.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  localparam int unsigned LG_W  = 4;
  localparam int unsigned OSR_W = 8;

  typedef enum logic [1:0] {
    RATE_NORM = 2'b00,
    RATE_DBL  = 2'b01,
    RATE_QUAD = 2'b10
  } rate_e;

  typedef struct packed {
    logic [LG_W-1:0]  frame_lg;
    logic [LG_W-1:0]  bclk_lg;
    logic [LG_W-1:0]  mod_lg;
    logic [OSR_W-1:0] osr;
  } div_cfg_t;

  function automatic rate_e decode_rate(input logic [1:0] sel);
    case (sel)
      2'b01:   return RATE_DBL;
      2'b10:   return RATE_QUAD;
      default: return RATE_NORM;
    endcase
  endfunction

  function automatic div_cfg_t rate_cfg(input rate_e r, input logic [LG_W-1:0] base_lg);
    div_cfg_t c;
    case (r)
      RATE_QUAD: begin c.frame_lg = base_lg - 1'b1; c.bclk_lg = 4'd1; c.mod_lg = 4'd2; c.osr = 8'd32;  end
      RATE_DBL:  begin c.frame_lg = base_lg;        c.bclk_lg = 4'd2; c.mod_lg = 4'd2; c.osr = 8'd64;  end
      default:   begin c.frame_lg = base_lg;        c.bclk_lg = 4'd2; c.mod_lg = 4'd1; c.osr = 8'd128; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/audio_div_counter.sv
module audio_div_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (restart_i || !run_i) cnt_o <= '0;
    else if (cnt_o == last_i)   cnt_o <= '0;
    else                        cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/audio_clk_taps.sv
module audio_clk_taps
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  div_cfg_t         cfg_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             mod_en_o
);

  logic [CNT_W-1:0] lr_sh, bc_sh, mod_mask;

  // half-period bit of each divider sits at log2(div)-1
  assign lr_sh    = cnt_i >> (cfg_i.frame_lg - 1'b1);
  assign bc_sh    = cnt_i >> (cfg_i.bclk_lg - 1'b1);
  assign mod_mask = (CNT_W'(1) << cfg_i.mod_lg) - 1'b1;

  assign lrclk_o  = en_i & lr_sh[0];
  assign bclk_o   = en_i & bc_sh[0];
  assign mod_en_o = en_i & ((cnt_i & mod_mask) == mod_mask);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned FRAME_LG = 8
) (
  input  logic             mclk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [1:0]       rate_sel_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             mod_en_o,
  output logic [OSR_W-1:0] osr_o
);

  localparam int unsigned CNT_W = FRAME_LG;

  rate_e            rate_d, rate_q;
  logic             master_q;
  logic             restart;
  div_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt, cnt_last;

  assign rate_d  = decode_rate(rate_sel_i);
  assign restart = (master_i != master_q) || (rate_d != rate_q);

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      rate_q   <= RATE_NORM;
    end else begin
      master_q <= master_i;
      rate_q   <= rate_d;
    end
  end

  assign cfg_q    = rate_cfg(rate_q, LG_W'(FRAME_LG));
  assign cnt_last = (CNT_W'(1) << cfg_q.frame_lg) - 1'b1;
  assign osr_o    = cfg_q.osr;

  audio_div_counter #(.CNT_W(CNT_W)) div_i (
    .clk_i    (mclk_i),
    .rst_ni   (rst_ni),
    .run_i    (master_q),
    .restart_i(restart),
    .last_i   (cnt_last),
    .cnt_o    (cnt)
  );

  audio_clk_taps #(.CNT_W(CNT_W)) taps_i (
    .en_i    (master_q),
    .cnt_i   (cnt),
    .cfg_i   (cfg_q),
    .bclk_o  (bclk_o),
    .lrclk_o (lrclk_o),
    .mod_en_o(mod_en_o)
  );

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       mclk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic [1:0] rate_sel_i,
  input logic       bclk_o,
  input logic       lrclk_o,
  input logic       mod_en_o,
  input logic [7:0] osr_o
);

  a_r8_slave_idle: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !master_i |=> (!bclk_o && !lrclk_o && !mod_en_o));

  a_r6_lr_on_bclk_fall: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (lrclk_o != $past(lrclk_o)) && ($past(master_i) == $past(master_i, 2)) &&
    ($past(rate_sel_i) == $past(rate_sel_i, 2)) |-> $fell(bclk_o));

  a_r7_mod_pulse: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    mod_en_o |=> !mod_en_o);

  a_r5_osr_dbl: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (rate_sel_i == 2'b01) |=> (osr_o == 8'd64));

  a_r5_osr_quad: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (rate_sel_i == 2'b10) |=> (osr_o == 8'd32));

  a_r9_restart_low: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (rate_sel_i == 2'b10) && ($past(rate_sel_i) == 2'b01) |=> (!lrclk_o && !bclk_o));

endmodule

bind audio_clkgen audio_clkgen_chk chk_i (
  .mclk_i    (mclk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .rate_sel_i(rate_sel_i),
  .bclk_o    (bclk_o),
  .lrclk_o   (lrclk_o),
  .mod_en_o  (mod_en_o),
  .osr_o     (osr_o)
);

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       master;
  logic [1:0] rate;
  logic       bclk, lrclk, mod_en;
  logic [7:0] osr;

  int  k;
  int  n_chk = 0, n_fail = 0;
  bit  fresh;
  logic bclk_p, lr_p, mod_p;

  always #2 clk = ~clk;

  audio_clkgen dut_i (
    .mclk_i(clk), .rst_ni(rst_n), .master_i(master), .rate_sel_i(rate),
    .bclk_o(bclk), .lrclk_o(lrclk), .mod_en_o(mod_en), .osr_o(osr)
  );

  function automatic int fdiv(logic [1:0] r); return (r == 2'b10) ? 128 : 256; endfunction
  function automatic int bdiv(logic [1:0] r); return (r == 2'b10) ? 2 : 4; endfunction
  function automatic int mdiv(logic [1:0] r); return (r == 2'b01 || r == 2'b10) ? 4 : 2; endfunction
  function automatic int osr_of(logic [1:0] r);
    return (r == 2'b01) ? 64 : (r == 2'b10) ? 32 : 128;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "osr", int'(osr), osr_of(rate));
    if (master) begin
      chk(tag, "lrclk", int'(lrclk), int'((k % fdiv(rate)) >= fdiv(rate) / 2));
      chk(tag, "bclk",  int'(bclk),  int'((k % bdiv(rate)) >= bdiv(rate) / 2));
      chk(tag, "mod_en", int'(mod_en), int'((k % mdiv(rate)) == mdiv(rate) - 1));
      if (fresh) begin
        chk("R9", "lrclk at restart", int'(lrclk), 0);
        chk("R9", "bclk at restart", int'(bclk), 0);
      end else if (lrclk != lr_p) begin
        chk("R6", "bclk fall at lrclk edge", int'({bclk_p, bclk}), 2);
      end
    end else begin
      chk("R8", "idle clocks", int'({bclk, lrclk, mod_en}), 0);
    end
    if (mod_p) chk("R7", "mod_en back-to-back", int'(mod_en), 0);
    bclk_p = bclk; lr_p = lrclk; mod_p = mod_en;
    fresh = 1'b0;
    k++;
  endtask

  // called at a negedge; restart=1 means the next edge is phase 0
  task automatic phase(logic m, logic [1:0] r, bit restart, int n, string tag);
    master = m;
    rate   = r;
    if (restart) begin k = 0; fresh = 1'b1; end
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master = 1'b1; rate = 2'b00;
    bclk_p = 1'b0; lr_p = 1'b0; mod_p = 1'b0; fresh = 1'b0; k = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset clocks", int'({bclk, lrclk, mod_en}), 0);
    chk("R1", "reset osr", int'(osr), 128);
    rst_n = 1'b1;
    phase(1'b1, 2'b00, 1'b1, 600, "R2");
    phase(1'b1, 2'b01, 1'b1, 600, "R3");
    phase(1'b1, 2'b10, 1'b1, 300, "R4");
    phase(1'b1, 2'b00, 1'b1, 150, "R2");
    phase(1'b1, 2'b11, 1'b0, 300, "R10");
    phase(1'b1, 2'b00, 1'b0, 100, "R10");
    phase(1'b0, 2'b00, 1'b1, 50, "R8");
    phase(1'b0, 2'b10, 1'b1, 50, "R8");
    phase(1'b1, 2'b10, 1'b1, 300, "R4");
    phase(1'b1, 2'b01, 1'b1, 70, "R3");
    phase(1'b1, 2'b10, 1'b1, 200, "R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule